// File: doc/BRIEF.md
# Bridge Configuration Cycle Router

This block sits on the upstream side of a bridge. It sorts every configuration request into one of four outcomes. The request may be claimed by the bridge's own register space. It may be sent on down the hierarchy as a Type 1 request. It may be turned into a Type 0 request with one ID-select line driven on the secondary bus. Or it may be refused, either as unsupported or as a master-abort. The bus-number registers and a mask of private devices come in as plain inputs from the surrounding configuration logic. The block only makes the routing decision. It does not run the bus cycle, move data or build completions.

The secondary bus has no ID-select line for the bridge itself: the bridge takes device 0 on that bus for its own registers. A mask bit set for a device keeps that device's ID-select from ever being asserted. Enumeration software therefore never sees the device, and a request to it ends in a master-abort. The decision is registered on the cycle after the request strobe and stays until the next strobe.

Top module: `cfg_cycle_router`

## Requirements
- R1: After reset, routeValid is 0, routeKind is 0 (none), idSel is all zeros and cfgAddr is 0.
- R2: The outputs take the decision for a request on the clock edge that samples reqValid high, so they are visible one cycle after the strobe. routeValid then stays 1, and routeKind, idSel and cfgAddr keep their values while reqValid is low, whatever the other inputs do.
- R3: A Type 0 request (reqIsType1=0) to device 0 is claimed locally (routeKind=1), with cfgAddr in Type 0 format. A Type 0 request to any other device is unsupported (routeKind=4) with cfgAddr=0.
- R4: A Type 1 request whose bus number is greater than secBus and no greater than subBus is forwarded (routeKind=2). cfgAddr then holds bits[1:0]=01, register dword reqReg[7:2] at [7:2], function at [10:8], device at [15:11], bus at [23:16], extended register bits at [27:24] and 0 at [31:28].
- R5: A Type 1 request whose bus number equals secBus, to a device d with 1 <= d < NUM_IDSEL that is not private, is converted (routeKind=3). idSel has exactly bit d set. cfgAddr is in Type 0 format: bits[1:0]=00, [7:2] dword, [10:8] function, [27:24] extended bits, everything else 0.
- R6: A Type 1 request to device 0 on the secondary bus is claimed locally (routeKind=1), with idSel all zeros and cfgAddr in Type 0 format. idSel bit 0 is never asserted.
- R7: A Type 1 request to a secondary-bus device whose privMask bit is 1 gives a master-abort (routeKind=5), with idSel and cfgAddr zero.
- R8: A Type 1 request to a secondary-bus device number of NUM_IDSEL or more gives a master-abort (routeKind=5), with idSel and cfgAddr zero.
- R9: A Type 1 request whose bus number is below secBus or above subBus, and is not priBus, is unsupported (routeKind=4). No ID-select is driven and cfgAddr is 0.
- R10: A Type 1 request whose bus number equals priBus, and that does not fall in the secondary range, is claimed locally when the device is 0. For any other device it is unsupported.
- R11: With reqLegacy=1 the extended register bits cfgAddr[27:24] are forced to 0. With reqLegacy=0 they carry reqReg[11:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqIsType1 | input | 1 | 1 = Type 1 request, 0 = Type 0 |
| reqLegacy | input | 1 | Request came through the 256-byte-compatible mechanism |
| reqBus | input | 8 | Target bus number |
| reqDev | input | 5 | Target device number |
| reqFunc | input | 3 | Target function number |
| reqReg | input | 12 | Byte register offset |
| priBus | input | 8 | Primary bus number |
| secBus | input | 8 | Secondary bus number |
| subBus | input | 8 | Subordinate bus number |
| privMask | input | NUM_IDSEL | 1 = device hidden (private) |
| routeValid | output | 1 | A decision has been made since reset |
| routeKind | output | 3 | 0 none, 1 local, 2 forward Type 1, 3 convert Type 0, 4 unsupported, 5 master-abort |
| idSel | output | NUM_IDSEL | One-hot ID-select for the converted cycle |
| cfgAddr | output | 32 | Translated configuration address |

## Verification
The checker module tests several things on every cycle. idSel is one-hot or zero, and its bit 0 stays low. A Type 0 conversion drives exactly one ID-select line, and every other outcome drives none. Forwarded addresses carry the Type 1 code. The outputs hold still between strobes. A strobe to a private device leads to a master-abort on the next cycle, and a legacy strobe leads to clear extended bits. The bench scenarios are needed to show the rest: the exact address fields, the bus-range edges at secBus, subBus and one past subBus, the primary-bus rule, and the device-number limit at NUM_IDSEL. Only there can the whole decision be compared against values computed independently.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FUNC_W    = 3;
  localparam int REG_W     = 12;
  localparam int LEG_REG_W = 8;
  localparam int EXT_W     = REG_W - LEG_REG_W;
  localparam int DW_W      = LEG_REG_W - 2;
  localparam int ADDR_W    = 32;

  // translated address field positions (decoded by the downstream cycle engine)
  localparam int DW_LSB   = 2;
  localparam int FUNC_LSB = DW_LSB + DW_W;
  localparam int DEV_LSB  = FUNC_LSB + FUNC_W;
  localparam int BUS_LSB  = DEV_LSB + DEV_W;
  localparam int EXT_LSB  = BUS_LSB + BUS_W;
  localparam int PAD_W    = ADDR_W - EXT_LSB - EXT_W;

  typedef enum logic [2:0] {
    RT_NONE  = 3'd0,
    RT_LOCAL = 3'd1,
    RT_FWD1  = 3'd2,
    RT_CONV0 = 3'd3,
    RT_UNSUP = 3'd4,
    RT_ABORT = 3'd5
  } route_e;

  typedef struct packed {
    logic   load;
    route_e kind;
  } ctl_strobe_t;
endpackage

// File: rtl/cfg_route_ctrl.sv
module cfg_route_ctrl
  import cfg_route_pkg::*;
#(
  parameter int NUM_IDSEL = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsType1,
  input  logic [BUS_W-1:0]     reqBus,
  input  logic [DEV_W-1:0]     reqDev,
  input  logic [BUS_W-1:0]     priBus,
  input  logic [BUS_W-1:0]     secBus,
  input  logic [BUS_W-1:0]     subBus,
  input  logic [NUM_IDSEL-1:0] privMask,
  output ctl_strobe_t          ctlStb,
  output logic                 routeValid
);
  localparam int IDX_W = (NUM_IDSEL > 1) ? $clog2(NUM_IDSEL) : 1;
  localparam logic [DEV_W:0] LINE_LIMIT = (DEV_W+1)'(NUM_IDSEL);

  logic   busIsSec, busInRange, busIsPri;
  logic   devIsZero, devHasLine, devPrivate;
  logic [IDX_W-1:0] devIdx;
  route_e kindNext;

  assign busIsSec   = (reqBus == secBus);
  assign busInRange = (reqBus > secBus) && (reqBus <= subBus);
  assign busIsPri   = (reqBus == priBus);
  assign devIsZero  = (reqDev == '0);
  assign devHasLine = ({1'b0, reqDev} < LINE_LIMIT);
  assign devIdx     = reqDev[IDX_W-1:0];

  always_comb begin
    devPrivate = 1'b0;
    if (devHasLine) devPrivate = privMask[devIdx];
  end

  // classification, first match wins
  always_comb begin
    kindNext = RT_UNSUP;
    if (!reqIsType1) begin
      kindNext = devIsZero ? RT_LOCAL : RT_UNSUP;
    end else if (busIsSec) begin
      if (devIsZero)        kindNext = RT_LOCAL;
      else if (!devHasLine) kindNext = RT_ABORT;
      else if (devPrivate)  kindNext = RT_ABORT;
      else                  kindNext = RT_CONV0;
    end else if (busInRange) begin
      kindNext = RT_FWD1;
    end else if (busIsPri) begin
      kindNext = devIsZero ? RT_LOCAL : RT_UNSUP;
    end else begin
      kindNext = RT_UNSUP;
    end
  end

  assign ctlStb.load = reqValid;
  assign ctlStb.kind = kindNext;

  always_ff @(posedge clk) begin
    if (!rstN)         routeValid <= 1'b0;
    else if (reqValid) routeValid <= 1'b1;
  end
endmodule

// File: rtl/cfg_route_dp.sv
module cfg_route_dp
  import cfg_route_pkg::*;
#(
  parameter int NUM_IDSEL = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_strobe_t          ctlStb,
  input  logic                 reqLegacy,
  input  logic [BUS_W-1:0]     reqBus,
  input  logic [DEV_W-1:0]     reqDev,
  input  logic [FUNC_W-1:0]    reqFunc,
  input  logic [REG_W-1:0]     reqReg,
  output route_e               route,
  output logic [NUM_IDSEL-1:0] idSel,
  output logic [ADDR_W-1:0]    cfgAddr
);
  logic [EXT_W-1:0]     extBits;
  logic [DW_W-1:0]      dwBits;
  logic [ADDR_W-1:0]    addrType1, addrType0, addrNext;
  logic [NUM_IDSEL-1:0] idSelNext;

  assign extBits = reqLegacy ? '0 : reqReg[REG_W-1:LEG_REG_W];
  assign dwBits  = reqReg[LEG_REG_W-1:DW_LSB];

  assign addrType1 = {{PAD_W{1'b0}}, extBits, reqBus, reqDev, reqFunc, dwBits, 2'b01};
  assign addrType0 = {{PAD_W{1'b0}}, extBits, {BUS_W{1'b0}}, {DEV_W{1'b0}},
                      reqFunc, dwBits, 2'b00};

  always_comb begin
    case (ctlStb.kind)
      RT_FWD1:            addrNext = addrType1;
      RT_CONV0, RT_LOCAL: addrNext = addrType0;
      default:            addrNext = '0;
    endcase
  end

  // one decoder leg per ID-select line
  for (genvar g = 0; g < NUM_IDSEL; g++) begin : g_sel
    assign idSelNext[g] = (ctlStb.kind == RT_CONV0) && (reqDev == DEV_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      route   <= RT_NONE;
      idSel   <= '0;
      cfgAddr <= '0;
    end else if (ctlStb.load) begin
      route   <= ctlStb.kind;
      idSel   <= idSelNext;
      cfgAddr <= addrNext;
    end
  end
endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
  import cfg_route_pkg::*;
#(
  parameter int NUM_IDSEL = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsType1,
  input  logic                 reqLegacy,
  input  logic [7:0]           reqBus,
  input  logic [4:0]           reqDev,
  input  logic [2:0]           reqFunc,
  input  logic [11:0]          reqReg,
  input  logic [7:0]           priBus,
  input  logic [7:0]           secBus,
  input  logic [7:0]           subBus,
  input  logic [NUM_IDSEL-1:0] privMask,
  output logic                 routeValid,
  output logic [2:0]           routeKind,
  output logic [NUM_IDSEL-1:0] idSel,
  output logic [31:0]          cfgAddr
);
  ctl_strobe_t ctlStb;
  route_e      routeQ;

  cfg_route_ctrl #(.NUM_IDSEL(NUM_IDSEL)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsType1(reqIsType1),
    .reqBus(reqBus), .reqDev(reqDev), .priBus(priBus), .secBus(secBus),
    .subBus(subBus), .privMask(privMask), .ctlStb(ctlStb), .routeValid(routeValid)
  );

  cfg_route_dp #(.NUM_IDSEL(NUM_IDSEL)) dp_i (
    .clk(clk), .rstN(rstN), .ctlStb(ctlStb), .reqLegacy(reqLegacy),
    .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc), .reqReg(reqReg),
    .route(routeQ), .idSel(idSel), .cfgAddr(cfgAddr)
  );

  assign routeKind = routeQ;
endmodule

// File: rtl/cfg_route_chk.sv
module cfg_route_chk #(
  parameter int NUM_IDSEL = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqIsType1,
  input logic                 reqLegacy,
  input logic [7:0]           reqBus,
  input logic [4:0]           reqDev,
  input logic [7:0]           secBus,
  input logic [NUM_IDSEL-1:0] privMask,
  input logic                 routeValid,
  input logic [2:0]           routeKind,
  input logic [NUM_IDSEL-1:0] idSel,
  input logic [31:0]          cfgAddr
);
  logic hiddenTarget;
  always_comb begin
    hiddenTarget = 1'b0;
    if (reqIsType1 && reqBus == secBus && reqDev != 5'd0 && 32'(reqDev) < NUM_IDSEL)
      hiddenTarget = privMask[reqDev[$clog2(NUM_IDSEL)-1:0]];
  end

  a_r5_idsel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(idSel));
  a_r6_dev0_no_line: assert property (@(posedge clk) disable iff (!rstN)
    !idSel[0]);
  a_r5_conv_one_line: assert property (@(posedge clk) disable iff (!rstN)
    routeKind == 3'd3 |-> $countones(idSel) == 1);
  a_r7_quiet_otherwise: assert property (@(posedge clk) disable iff (!rstN)
    routeKind != 3'd3 |-> idSel == '0);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> routeValid);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(routeKind) && $stable(idSel) && $stable(cfgAddr)));
  a_r4_fwd_code: assert property (@(posedge clk) disable iff (!rstN)
    routeKind == 3'd2 |-> cfgAddr[1:0] == 2'b01);
  a_r7_private_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && hiddenTarget) |=> routeKind == 3'd5);
  a_r11_legacy_clear: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLegacy) |=> cfgAddr[27:24] == 4'h0);
endmodule

bind cfg_cycle_router cfg_route_chk #(.NUM_IDSEL(NUM_IDSEL)) chk_i (.*);

// File: tb/cfg_cycle_router_tb_top.sv
`timescale 1ns/1ps
module cfg_cycle_router_tb_top;
  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqIsType1 = 1'b0, reqLegacy = 1'b0;
  logic [7:0]    reqBus = '0;
  logic [4:0]    reqDev = '0;
  logic [2:0]    reqFunc = '0;
  logic [11:0]   reqReg = '0;
  logic [7:0]    priBus = 8'd1, secBus = 8'd4, subBus = 8'd9;
  logic [NI-1:0] privMask = 16'h0020;
  logic          routeValid;
  logic [2:0]    routeKind;
  logic [NI-1:0] idSel;
  logic [31:0]   cfgAddr;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cfg_cycle_router #(.NUM_IDSEL(NI)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsType1(reqIsType1),
    .reqLegacy(reqLegacy), .reqBus(reqBus), .reqDev(reqDev), .reqFunc(reqFunc),
    .reqReg(reqReg), .priBus(priBus), .secBus(secBus), .subBus(subBus),
    .privMask(privMask), .routeValid(routeValid), .routeKind(routeKind),
    .idSel(idSel), .cfgAddr(cfgAddr)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] a1(logic [7:0] b, logic [4:0] d, logic [2:0] f,
                                     logic [11:0] r, logic leg);
    return {4'h0, leg ? 4'h0 : r[11:8], b, d, f, r[7:2], 2'b01};
  endfunction

  function automatic logic [31:0] a0(logic [2:0] f, logic [11:0] r, logic leg);
    return {4'h0, leg ? 4'h0 : r[11:8], 8'h0, 5'h0, f, r[7:2], 2'b00};
  endfunction

  // one strobe; outputs are sampled at the following falling edge
  task automatic issue(logic t1, logic leg, logic [7:0] b, logic [4:0] d,
                       logic [2:0] f, logic [11:0] r);
    @(negedge clk);
    reqIsType1 = t1; reqLegacy = leg; reqBus = b; reqDev = d; reqFunc = f; reqReg = r;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expect_route(string req, logic [2:0] k, logic [NI-1:0] s, logic [31:0] a);
    chk(req, "routeValid", 32'(routeValid), 32'd1);
    chk(req, "routeKind", 32'(routeKind), 32'(k));
    chk(req, "idSel", 32'(idSel), 32'(s));
    chk(req, "cfgAddr", cfgAddr, a);
  endtask

  task automatic t_reset;
    chk("R1", "routeValid", 32'(routeValid), 32'd0);
    chk("R1", "routeKind", 32'(routeKind), 32'd0);
    chk("R1", "idSel", 32'(idSel), 32'd0);
    chk("R1", "cfgAddr", cfgAddr, 32'd0);
  endtask

  task automatic t_type0;
    issue(1'b0, 1'b0, 8'd0, 5'd0, 3'd2, 12'h10C);
    expect_route("R3", 3'd1, '0, a0(3'd2, 12'h10C, 1'b0));
    issue(1'b0, 1'b0, 8'd0, 5'd3, 3'd0, 12'h004);
    expect_route("R3", 3'd4, '0, 32'd0);
  endtask

  task automatic t_forward;
    issue(1'b1, 1'b0, 8'd7, 5'd12, 3'd1, 12'h2A8);
    expect_route("R4", 3'd2, '0, a1(8'd7, 5'd12, 3'd1, 12'h2A8, 1'b0));
    issue(1'b1, 1'b0, 8'd9, 5'd31, 3'd7, 12'h0FC);
    expect_route("R4", 3'd2, '0, a1(8'd9, 5'd31, 3'd7, 12'h0FC, 1'b0));
    issue(1'b1, 1'b0, 8'd5, 5'd0, 3'd0, 12'h000);
    expect_route("R4", 3'd2, '0, a1(8'd5, 5'd0, 3'd0, 12'h000, 1'b0));
  endtask

  task automatic t_convert;
    issue(1'b1, 1'b0, 8'd4, 5'd9, 3'd0, 12'h040);
    expect_route("R5", 3'd3, NI'(1) << 9, a0(3'd0, 12'h040, 1'b0));
    issue(1'b1, 1'b0, 8'd4, 5'd15, 3'd6, 12'h7F8);
    expect_route("R5", 3'd3, NI'(1) << 15, a0(3'd6, 12'h7F8, 1'b0));
    issue(1'b1, 1'b0, 8'd4, 5'd1, 3'd3, 12'h018);
    expect_route("R5", 3'd3, NI'(1) << 1, a0(3'd3, 12'h018, 1'b0));
  endtask

  task automatic t_dev0_secondary;
    issue(1'b1, 1'b0, 8'd4, 5'd0, 3'd4, 12'h0A0);
    expect_route("R6", 3'd1, '0, a0(3'd4, 12'h0A0, 1'b0));
  endtask

  task automatic t_private;
    issue(1'b1, 1'b0, 8'd4, 5'd5, 3'd0, 12'h000);
    expect_route("R7", 3'd5, '0, 32'd0);
    privMask = 16'h0000;
    issue(1'b1, 1'b0, 8'd4, 5'd5, 3'd0, 12'h000);
    expect_route("R7", 3'd3, NI'(1) << 5, a0(3'd0, 12'h000, 1'b0));
    privMask = 16'h0020;
  endtask

  task automatic t_no_line;
    issue(1'b1, 1'b0, 8'd4, 5'd16, 3'd0, 12'h010);
    expect_route("R8", 3'd5, '0, 32'd0);
    issue(1'b1, 1'b0, 8'd4, 5'd31, 3'd1, 12'h010);
    expect_route("R8", 3'd5, '0, 32'd0);
  endtask

  task automatic t_out_of_range;
    issue(1'b1, 1'b0, 8'd10, 5'd2, 3'd0, 12'h000);
    expect_route("R9", 3'd4, '0, 32'd0);
    issue(1'b1, 1'b0, 8'd3, 5'd2, 3'd0, 12'h000);
    expect_route("R9", 3'd4, '0, 32'd0);
    issue(1'b1, 1'b0, 8'd0, 5'd0, 3'd0, 12'h000);
    expect_route("R9", 3'd4, '0, 32'd0);
  endtask

  task automatic t_primary;
    issue(1'b1, 1'b0, 8'd1, 5'd0, 3'd1, 12'h3C4);
    expect_route("R10", 3'd1, '0, a0(3'd1, 12'h3C4, 1'b0));
    issue(1'b1, 1'b0, 8'd1, 5'd2, 3'd0, 12'h000);
    expect_route("R10", 3'd4, '0, 32'd0);
  endtask

  task automatic t_legacy;
    issue(1'b1, 1'b1, 8'd6, 5'd3, 3'd2, 12'hF3C);
    expect_route("R11", 3'd2, '0, a1(8'd6, 5'd3, 3'd2, 12'hF3C, 1'b1));
    issue(1'b1, 1'b0, 8'd6, 5'd3, 3'd2, 12'hF3C);
    chk("R11", "extBits", 32'(cfgAddr[27:24]), 32'hF);
    issue(1'b1, 1'b1, 8'd4, 5'd7, 3'd0, 12'h904);
    expect_route("R11", 3'd3, NI'(1) << 7, a0(3'd0, 12'h904, 1'b1));
  endtask

  task automatic t_hold;
    issue(1'b1, 1'b0, 8'd4, 5'd11, 3'd5, 12'h214);
    reqBus = 8'd8; reqDev = 5'd2; reqReg = 12'hFFF; reqIsType1 = 1'b0;
    privMask = 16'hFFFF;
    repeat (3) @(negedge clk);
    expect_route("R2", 3'd3, NI'(1) << 11, a0(3'd5, 12'h214, 1'b0));
    privMask = 16'h0020;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_type0();
    t_forward();
    t_convert();
    t_dev0_secondary();
    t_private();
    t_no_line();
    t_out_of_range();
    t_primary();
    t_legacy();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule